// File: doc/BRIEF.md
# Address-Latched Multicart Bank Mapper

This block is the banking controller of a multi-game cartridge for an 8-bit console. It takes its settings from the address lines rather than the data bus. Any CPU write that lands in the upper 32 KiB window stores a few bits of the write address: a three-bit bank number, a mirroring bit and a banking-style bit. The value on the data bus plays no part. From that stored setting it forms the full program-ROM address, the full character-ROM address and the console-RAM A10 select that sets nametable mirroring.

The banking-style bit picks between two program layouts. In the first, one 16 KiB bank appears twice, at $8000 and at $C000. In the second, a 32 KiB bank fills the whole upper window. The character bank is always 8 KiB and always uses all three bank bits.

The block also answers one narrow, address-masked CPU read range with a constant high bit 7. Every other bit in that range, and every other read, is left undriven. A per-bit output-enable vector tells the board which data lines to drive.

Top module: `multicart_bank_mapper`

## Requirements
- R1: After reset the stored setting is bank 0, 16 KiB style and vertical mirroring: chr_addr[15:13]=0, prg_addr[16:14]=0 and ciram_a10 follows ppu_addr[10].
- R2: On a rising clk with cpu_rw=0 and cpu_addr[15]=1, the block stores cpu_addr[14] as the style bit, cpu_addr[3] as the mirroring bit and cpu_addr[2:0] as the bank; the new setting shows at the outputs after that edge.
- R3: A rising clk with cpu_rw=1, or with cpu_addr[15]=0, leaves the stored setting unchanged.
- R4: With style bit 0, prg_addr[16:14] equals the bank, whatever cpu_addr[14] is, and prg_addr[13:0] equals cpu_addr[13:0].
- R5: With style bit 1, prg_addr[16:15] equals bank[2:1], prg_addr[14] equals cpu_addr[14], and prg_addr[13:0] equals cpu_addr[13:0].
- R6: In both styles chr_addr[15:13] equals the bank and chr_addr[12:0] equals ppu_addr[12:0].
- R7: ciram_a10 equals ppu_addr[10] when the mirroring bit is 0 (vertical) and ppu_addr[11] when it is 1 (horizontal).
- R8: When cpu_rw=1 and (cpu_addr & 16'hE010) == 16'h6000, cpu_oe is 8'h80 and cpu_rdata[7] is 1.
- R9: For every other bus state, including writes, cpu_oe is 8'h00 and cpu_rdata is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; the setting is stored on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| ppu_addr | input | 13 | PPU address bits 12..0 |
| prg_addr | output | 17 | Program-ROM address |
| chr_addr | output | 16 | Character-ROM address |
| ciram_a10 | output | 1 | Console nametable RAM A10 select |
| cpu_rdata | output | 8 | Value to drive onto the CPU data bus |
| cpu_oe | output | 8 | Per-bit drive enable for cpu_rdata |

## Verification
The assertions assume that cpu_rw and cpu_addr are stable around the rising clock edge, so a write is judged by what the bus holds at that edge. They also assume reset is held for at least one edge before any bus activity. The bench meets both assumptions. It changes every input on the falling edge only, samples the outputs one nanosecond later, and keeps rst_n low for several edges before its first access. The stimulus mixes directed accesses with seeded pseudo-random ones, so reads, low-window writes and upper-window writes all occur in both banking styles and both mirroring settings.

// File: rtl/multicart_bank_mapper.sv
module multicart_bank_mapper #(
  parameter int          CPU_AW    = 16,
  parameter int          PPU_AW    = 13,
  parameter int          DW        = 8,
  parameter int          BANK_W    = 3,
  parameter int          STYLE_BIT = 14,
  parameter int          MIRR_BIT  = 3,
  parameter logic [15:0] RD_MASK   = 16'hE010,
  parameter logic [15:0] RD_MATCH  = 16'h6000,
  localparam int         PRG_AW    = BANK_W + 14,
  localparam int         CHR_AW    = BANK_W + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              ciram_a10,
  output logic [DW-1:0]     cpu_rdata,
  output logic [DW-1:0]     cpu_oe
);

  logic              style_q;
  logic              mirr_q;
  logic [BANK_W-1:0] bank_q;
  logic              hit_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      style_q <= 1'b0;
      mirr_q  <= 1'b0;
      bank_q  <= '0;
    end else if (!cpu_rw && cpu_addr[CPU_AW-1]) begin
      style_q <= cpu_addr[STYLE_BIT];
      mirr_q  <= cpu_addr[MIRR_BIT];
      bank_q  <= cpu_addr[BANK_W-1:0];
    end
  end

  assign prg_addr[13:0]       = cpu_addr[13:0];
  assign prg_addr[PRG_AW-1:15] = bank_q[BANK_W-1:1];
  assign prg_addr[14]         = style_q ? cpu_addr[14] : bank_q[0];

  assign chr_addr  = {bank_q, ppu_addr[12:0]};
  assign ciram_a10 = mirr_q ? ppu_addr[11] : ppu_addr[10];

  assign hit_rd    = cpu_rw && ((cpu_addr & RD_MASK) == RD_MATCH);
  assign cpu_oe    = {hit_rd, {(DW-1){1'b0}}};
  assign cpu_rdata = {hit_rd, {(DW-1){1'b0}}};

endmodule

module multicart_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rw,
  input logic [12:0] ppu_addr,
  input logic [16:0] prg_addr,
  input logic [15:0] chr_addr,
  input logic        ciram_a10,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  cpu_oe
);

  assert_reset_bank_R1: assert property (@(posedge clk)
    !rst_n |=> chr_addr[15:13] == 3'd0 && prg_addr[16:14] == 3'd0);

  assert_write_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rw && cpu_addr[15]) |=> chr_addr[15:13] == $past(cpu_addr[2:0]));

  assert_hold_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rw || !cpu_addr[15]) |=> $stable(chr_addr[15:13]));

  assert_prg_chr_share_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prg_addr[16:15] == chr_addr[15:14]);

  assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr[12:0] == ppu_addr && prg_addr[13:0] == cpu_addr[13:0]);

  assert_mirror_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ciram_a10 == ppu_addr[10] || ciram_a10 == ppu_addr[11]);

  assert_only_bit7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_oe != 8'h00) |-> cpu_oe == 8'h80 && cpu_rdata[7] && cpu_rw);

  assert_no_drive_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rw |-> cpu_oe == 8'h00 && $countones(cpu_rdata) == 0);

endmodule

bind multicart_bank_mapper multicart_bank_mapper_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
  .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
  .ciram_a10(ciram_a10), .cpu_rdata(cpu_rdata), .cpu_oe(cpu_oe)
);

// File: tb/multicart_bank_mapper_tb.sv
`timescale 1ns/1ps
module multicart_bank_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rw = 1'b1;
  logic [12:0] ppu_addr = 13'h0000;
  logic [16:0] prg_addr;
  logic [15:0] chr_addr;
  logic        ciram_a10;
  logic [7:0]  cpu_rdata;
  logic [7:0]  cpu_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int m_style = 0;
  int m_mirr = 0;
  int m_bank = 0;

  always #2.5 clk = ~clk;

  multicart_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
    .ciram_a10(ciram_a10), .cpu_rdata(cpu_rdata), .cpu_oe(cpu_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h addr=0x%0h rw=%0d", tag, act, exp, cpu_addr, cpu_rw);
    end
  endtask

  task automatic compare(input string ctag);
    int e_prg;
    int e_oe;
    bit win;
    if (m_style == 0) begin
      e_prg = (m_bank << 14) | (cpu_addr & 16'h3FFF);
      chk("R4 prg_addr", prg_addr, e_prg);
    end else begin
      e_prg = ((m_bank >> 1) << 15) | (cpu_addr & 16'h7FFF);
      chk("R5 prg_addr", prg_addr, e_prg);
    end
    chk({ctag, " chr_addr"}, chr_addr, (m_bank << 13) | ppu_addr);
    chk("R7 ciram_a10", ciram_a10, m_mirr ? ppu_addr[11] : ppu_addr[10]);
    win = cpu_rw && ((cpu_addr & 16'hE010) == 16'h6000);
    e_oe = win ? 8'h80 : 8'h00;
    chk(win ? "R8 cpu_oe" : "R9 cpu_oe", cpu_oe, e_oe);
    chk(win ? "R8 cpu_rdata" : "R9 cpu_rdata", cpu_rdata, e_oe);
  endtask

  // one bus cycle: drive at falling edge, compare, then model the rising edge
  task automatic bus(input logic [15:0] a, input logic rw, input logic [12:0] p, input string ctag);
    @(negedge clk);
    cpu_addr = a;
    cpu_rw = rw;
    ppu_addr = p;
    #1;
    compare(ctag);
    @(posedge clk);
    if (!rw && a[15]) begin
      m_style = a[14];
      m_mirr = a[3];
      m_bank = a[2:0];
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    string t;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ppu_addr = 13'h0400;
    #1;
    chk("R1 chr bank", chr_addr[15:13], 0);
    chk("R1 prg bank", prg_addr[16:14], 0);
    chk("R1 vertical", ciram_a10, 1);

    bus(16'hC00D, 1'b0, 13'h0C00, "R6");
    bus(16'h4000, 1'b1, 13'h0800, "R2");
    bus(16'h1FFF, 1'b0, 13'h0400, "R2");
    bus(16'hF00E, 1'b1, 13'h0400, "R3");
    bus(16'h0000, 1'b1, 13'h0000, "R3");
    bus(16'h8005, 1'b0, 13'h1ABC, "R6");
    bus(16'hC123, 1'b1, 13'h0800, "R2");
    bus(16'h6000, 1'b1, 13'h0000, "R6");
    bus(16'h6010, 1'b1, 13'h0000, "R6");
    bus(16'h7FEF, 1'b1, 13'h0000, "R6");
    bus(16'h6000, 1'b0, 13'h0000, "R6");
    bus(16'h400F, 1'b0, 13'h0000, "R6");
    bus(16'h8000, 1'b1, 13'h0000, "R3");
    bus(16'hBFFF, 1'b1, 13'h1FFF, "R6");

    void'($urandom(32'd212));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic rw;
      a = 16'($urandom);
      rw = 1'($urandom);
      if (i % 7 == 0) a = (a & 16'h1FEF) | 16'h6000;
      t = (i > 0) ? "R2" : "R6";
      bus(a, rw, 13'($urandom), t);
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    m_style = 0; m_mirr = 0; m_bank = 0;
    @(negedge clk);
    rst_n = 1'b1;
    cpu_rw = 1'b1;
    #1;
    compare("R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule